// File: doc/BRIEF.md
# Time-Sliced Round-Robin Bus Arbiter

This block lets several requester ports share one memory request bus that carries two transmit channels. A port raises its want-transmit bit and offers an 8-bit slice length. The arbiter visits ports in round-robin order. When it finds a port that wants the bus, it grants that port the bus for the whole slice. During the slice it copies that port's two transmit channels onto the shared bus.

When a slice ends, the grant bit drops at once, but the arbiter keeps relaying the same port's channels for two more cycles. Requests that were already in a deep pipeline inside the requester therefore still reach the bus. The arbiter then scans the ports one per cycle, starting with the port after the one it last served.

The two near-full flags of the shared bus go straight to every port. Back-pressure is advisory: each requester must check its channel's full flag before it asserts a channel valid, and the arbiter never holds back or drops a relayed beat. The receive channel is broadcast to every port unchanged, and each requester picks out its own responses.

Top module: `slice_arb`

## Requirements
- R1: After reset, port 0 holds the grant (bit 0 of `req_grant`) for exactly one cycle. The two grace cycles of R4 follow, and scanning then starts at port 1.
- R2: At most one bit of `req_grant` is high in any cycle. Bit i is the grant of port i.
- R3: A grant lasts exactly as many consecutive cycles as the granting port's cycles-wanted field (`req_cycles[i*8 +: 8]`), sampled in the cycle the port is found. A value of 0 gives a one-cycle slice.
- R4: For the two cycles after a grant falls, `req_grant` stays all zero. The shared bus still carries the channel valids and data of the port that was last granted.
- R5: After the grace cycles and until the next grant, both shared channel valids are low.
- R6: While port i is granted, each shared channel valid equals port i's valid for that channel, and each shared channel's data equals port i's data when that valid is high. Channel 0 data is packed at `[i*W0 +: W0]` and channel 1 data at `[i*W1 +: W1]`. The valids of all other ports have no effect.
- R7: Scanning examines one port per cycle, starting with the port after the one last granted and wrapping from N-1 to 0. If the last grant ended in cycle t, a port j positions later (1 ≤ j ≤ N, where j = N means the same port again) that wants the bus is granted from cycle t+3+j. This gives 2+j idle grant cycles between the slices. A port that is not wanting when it is examined is passed over.
- R8: `req_c0_full` and `req_c1_full` copy `bus_c0_full` and `bus_c1_full` to every port in the same cycle.
- R9: `req_rx_valid` and `req_rx_data` copy the receive channel to every port in the same cycle, whichever port holds the grant.
- R10: When no port wants the bus, no grant is given and the scan keeps cycling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_want | input | N | Want-transmit bit per port |
| req_cycles | input | 8*N | Requested slice length per port |
| req_grant | output | N | Transmit-ready grant per port |
| req_c0_valid | input | N | Channel 0 request valid per port |
| req_c0_data | input | W0*N | Channel 0 request payload per port |
| req_c1_valid | input | N | Channel 1 request valid per port |
| req_c1_data | input | W1*N | Channel 1 request payload per port |
| req_c0_full | output | N | Channel 0 near-full flag, to every port |
| req_c1_full | output | N | Channel 1 near-full flag, to every port |
| req_rx_valid | output | N | Receive valid, broadcast |
| req_rx_data | output | RXW*N | Receive payload, broadcast |
| bus_c0_valid | output | 1 | Shared channel 0 valid |
| bus_c0_data | output | W0 | Shared channel 0 payload |
| bus_c1_valid | output | 1 | Shared channel 1 valid |
| bus_c1_data | output | W1 | Shared channel 1 payload |
| bus_c0_full | input | 1 | Shared channel 0 near-full |
| bus_c1_full | input | 1 | Shared channel 1 near-full |
| bus_rx_valid | input | 1 | Shared receive valid |
| bus_rx_data | input | RXW | Shared receive payload |

## Verification
Relay, full-flag and receive paths are combinational from the port inputs, so their results are due in the same cycle. The bench drives inputs just after a rising edge and samples on the falling edge of that cycle. Grant timing is registered: a slice of L cycles is followed by exactly 2+j cycles without a grant before the port j positions later is granted. The scoreboard records each expected slice as a port, a length and a gap, and the monitor measures all three edge by edge. Grace-cycle relaying and the quiet bus during scanning are checked in every idle cycle, split by the count of cycles since the grant fell.

// File: rtl/slice_arb_pkg.sv
package slice_arb_pkg;
  typedef enum logic [1:0] {
    ST_RELAY  = 2'd0,
    ST_STOP   = 2'd1,
    ST_STOP2  = 2'd2,
    ST_CHANGE = 2'd3
  } arb_state_e;
endpackage

// File: rtl/slice_arb_timer.sv
// Slice length counter: holds remaining grant cycles, last when one is left.
module slice_arb_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(1);
    end else if (load) begin
      cnt_q <= (load_val == '0) ? CNT_W'(1) : load_val;
    end else if (tick && !last) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/slice_arb_scan.sv
// Round-robin scan pointer: one port examined per cycle.
module slice_arb_scan #(
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [IDX_W-1:0]     base_idx,
  input  logic                 step,
  input  logic [NUM_PORTS-1:0] want,
  output logic [IDX_W-1:0]     scan_idx,
  output logic                 hit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

  logic [IDX_W-1:0] scan_q;

  function automatic logic [IDX_W-1:0] wrap_next(input logic [IDX_W-1:0] x);
    return (x == LAST_IDX) ? '0 : x + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_q <= '0;
    end else if (start) begin
      scan_q <= wrap_next(base_idx);
    end else if (step) begin
      scan_q <= wrap_next(scan_q);
    end
  end

  assign scan_idx = scan_q;
  assign hit      = want[scan_q];
endmodule

// File: rtl/slice_arb_relay.sv
// One transmit channel: AND-OR selection of the chosen port onto the bus.
module slice_arb_relay #(
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2,
  parameter int W         = 16
) (
  input  logic [IDX_W-1:0]       sel,
  input  logic                   en,
  input  logic [NUM_PORTS-1:0]   in_valid,
  input  logic [NUM_PORTS*W-1:0] in_data,
  output logic                   out_valid,
  output logic [W-1:0]           out_data
);
  logic [NUM_PORTS-1:0]   pick;
  logic [NUM_PORTS-1:0]   masked_v;
  logic [NUM_PORTS*W-1:0] masked_d;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_lane
    assign pick[i]              = en && (sel == IDX_W'(i));
    assign masked_v[i]          = pick[i] & in_valid[i];
    assign masked_d[i*W +: W]   = pick[i] ? in_data[i*W +: W] : '0;
  end

  always_comb begin
    out_data = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      out_data = out_data | masked_d[i*W +: W];
    end
  end

  assign out_valid = |masked_v;
endmodule

// File: rtl/slice_arb.sv
module slice_arb #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 8,
  parameter int W0        = 16,
  parameter int W1        = 24,
  parameter int RXW       = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_PORTS-1:0]     req_want,
  input  logic [NUM_PORTS*CNT_W-1:0] req_cycles,
  output logic [NUM_PORTS-1:0]     req_grant,
  input  logic [NUM_PORTS-1:0]     req_c0_valid,
  input  logic [NUM_PORTS*W0-1:0]  req_c0_data,
  input  logic [NUM_PORTS-1:0]     req_c1_valid,
  input  logic [NUM_PORTS*W1-1:0]  req_c1_data,
  output logic [NUM_PORTS-1:0]     req_c0_full,
  output logic [NUM_PORTS-1:0]     req_c1_full,
  output logic [NUM_PORTS-1:0]     req_rx_valid,
  output logic [NUM_PORTS*RXW-1:0] req_rx_data,
  output logic                     bus_c0_valid,
  output logic [W0-1:0]            bus_c0_data,
  output logic                     bus_c1_valid,
  output logic [W1-1:0]            bus_c1_data,
  input  logic                     bus_c0_full,
  input  logic                     bus_c1_full,
  input  logic                     bus_rx_valid,
  input  logic [RXW-1:0]           bus_rx_data
);
  import slice_arb_pkg::*;

  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  arb_state_e       state_q, state_d;
  logic [IDX_W-1:0] cur_q;
  logic [IDX_W-1:0] scan_idx;
  logic             scan_hit;
  logic             slice_last;
  logic [CNT_W-1:0] found_cycles;
  logic             found;
  logic             relay_en;

  assign found    = (state_q == ST_CHANGE) && scan_hit;
  assign relay_en = (state_q != ST_CHANGE);

  always_comb begin
    found_cycles = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (scan_idx == IDX_W'(i)) found_cycles = req_cycles[i*CNT_W +: CNT_W];
    end
  end

  slice_arb_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (found),
    .load_val (found_cycles),
    .tick     (state_q == ST_RELAY),
    .last     (slice_last)
  );

  slice_arb_scan #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (state_q == ST_STOP2),
    .base_idx (cur_q),
    .step     ((state_q == ST_CHANGE) && !scan_hit),
    .want     (req_want),
    .scan_idx (scan_idx),
    .hit      (scan_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RELAY:  if (slice_last) state_d = ST_STOP;
      ST_STOP:   state_d = ST_STOP2;
      ST_STOP2:  state_d = ST_CHANGE;
      ST_CHANGE: if (scan_hit) state_d = ST_RELAY;
      default:   state_d = ST_CHANGE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RELAY;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      if (found) cur_q <= scan_idx;
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign req_grant[i]               = (state_q == ST_RELAY) && (cur_q == IDX_W'(i));
    assign req_c0_full[i]             = bus_c0_full;
    assign req_c1_full[i]             = bus_c1_full;
    assign req_rx_valid[i]            = bus_rx_valid;
    assign req_rx_data[i*RXW +: RXW]  = bus_rx_data;
  end

  slice_arb_relay #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W), .W(W0)) u_relay_c0 (
    .sel       (cur_q),
    .en        (relay_en),
    .in_valid  (req_c0_valid),
    .in_data   (req_c0_data),
    .out_valid (bus_c0_valid),
    .out_data  (bus_c0_data)
  );

  slice_arb_relay #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W), .W(W1)) u_relay_c1 (
    .sel       (cur_q),
    .en        (relay_en),
    .in_valid  (req_c1_valid),
    .in_data   (req_c1_data),
    .out_valid (bus_c1_valid),
    .out_data  (bus_c1_data)
  );
endmodule

// File: rtl/slice_arb_chk.sv
module slice_arb_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input slice_arb_pkg::arb_state_e    state,
  input logic [NUM_PORTS-1:0]         req_grant,
  input logic [NUM_PORTS-1:0]         req_want,
  input logic [NUM_PORTS-1:0]         req_c0_valid,
  input logic [NUM_PORTS-1:0]         req_c1_valid,
  input logic                         bus_c0_valid,
  input logic                         bus_c1_valid
);
  import slice_arb_pkg::*;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant)); // R2

  AST_GRACE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|req_grant) |=> (req_grant == '0)); // R4

  AST_QUIET_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHANGE) |-> (!bus_c0_valid && !bus_c1_valid)); // R5

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    AST_RELAY_C0: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[i] |-> (bus_c0_valid == req_c0_valid[i])); // R6
    AST_RELAY_C1: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[i] |-> (bus_c1_valid == req_c1_valid[i])); // R6
    AST_GRANT_FROM_WANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_grant[i]) |-> $past(req_want[i])); // R7
  end
endmodule

bind slice_arb slice_arb_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state        (state_q),
  .req_grant    (req_grant),
  .req_want     (req_want),
  .req_c0_valid (req_c0_valid),
  .req_c1_valid (req_c1_valid),
  .bus_c0_valid (bus_c0_valid),
  .bus_c1_valid (bus_c1_valid)
);

// File: tb/tb_slice_arb.sv
module tb_slice_arb;
  localparam int N   = 4;
  localparam int CW  = 8;
  localparam int W0  = 16;
  localparam int W1  = 24;
  localparam int RXW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]     req_want = '0;
  logic [N*CW-1:0]  req_cycles = '0;
  logic [N-1:0]     req_grant;
  logic [N-1:0]     req_c0_valid = '0;
  logic [N*W0-1:0]  req_c0_data = '0;
  logic [N-1:0]     req_c1_valid = '0;
  logic [N*W1-1:0]  req_c1_data = '0;
  logic [N-1:0]     req_c0_full, req_c1_full, req_rx_valid;
  logic [N*RXW-1:0] req_rx_data;
  logic             bus_c0_valid, bus_c1_valid;
  logic [W0-1:0]    bus_c0_data;
  logic [W1-1:0]    bus_c1_data;
  logic             bus_c0_full = 1'b0, bus_c1_full = 1'b0, bus_rx_valid = 1'b0;
  logic [RXW-1:0]   bus_rx_data = '0;

  always #2 clk = ~clk;

  slice_arb #(.NUM_PORTS(N), .CNT_W(CW), .W0(W0), .W1(W1), .RXW(RXW)) dut (
    .clk(clk), .rst_n(rst_n), .req_want(req_want), .req_cycles(req_cycles),
    .req_grant(req_grant), .req_c0_valid(req_c0_valid), .req_c0_data(req_c0_data),
    .req_c1_valid(req_c1_valid), .req_c1_data(req_c1_data),
    .req_c0_full(req_c0_full), .req_c1_full(req_c1_full),
    .req_rx_valid(req_rx_valid), .req_rx_data(req_rx_data),
    .bus_c0_valid(bus_c0_valid), .bus_c0_data(bus_c0_data),
    .bus_c1_valid(bus_c1_valid), .bus_c1_data(bus_c1_data),
    .bus_c0_full(bus_c0_full), .bus_c1_full(bus_c1_full),
    .bus_rx_valid(bus_rx_valid), .bus_rx_data(bus_rx_data)
  );

  typedef struct {int port; int len; int gap;} slice_t;
  slice_t sb_q[$];

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic push_slice(input int port, input int len, input int gap);
    slice_t s;
    s.port = port; s.len = len; s.gap = gap;
    sb_q.push_back(s);
  endtask

  // Monitor: measures grant runs and idle gaps, checks relay and quiet bus.
  slice_t cur_item;
  bit     in_run = 0;
  bit     have_last = 0;
  int     run_len = 0;
  int     zero_run = 1000;
  int     last_port = 0;

  initial begin
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (|req_grant) begin
        int gp = 0;
        for (int p = 0; p < N; p++) if (req_grant[p]) gp = p;
        if (!in_run) begin
          in_run = 1; run_len = 1;
          if (sb_q.size() == 0) begin
            chk(0, "R7 unexpected grant", gp, -1);
            cur_item.port = gp; cur_item.len = 0; cur_item.gap = -1;
          end else begin
            cur_item = sb_q.pop_front();
            chk(gp == cur_item.port, "R7 granted port", gp, cur_item.port);
            if (cur_item.gap >= 0)
              chk(zero_run == cur_item.gap, "R7 gap before grant", zero_run, cur_item.gap);
          end
        end else begin
          run_len++;
          chk(gp == last_port, "R3 port held through slice", gp, last_port);
        end
        chk(bus_c0_valid == req_c0_valid[gp], "R6 c0 valid relay", int'(bus_c0_valid), int'(req_c0_valid[gp]));
        chk(bus_c1_valid == req_c1_valid[gp], "R6 c1 valid relay", int'(bus_c1_valid), int'(req_c1_valid[gp]));
        if (req_c0_valid[gp])
          chk(bus_c0_data == req_c0_data[gp*W0 +: W0], "R6 c0 data relay", int'(bus_c0_data), int'(req_c0_data[gp*W0 +: W0]));
        if (req_c1_valid[gp])
          chk(bus_c1_data == req_c1_data[gp*W1 +: W1], "R6 c1 data relay", int'(bus_c1_data), int'(req_c1_data[gp*W1 +: W1]));
        last_port = gp; have_last = 1;
      end else begin
        if (in_run) begin
          in_run = 0;
          chk(run_len == cur_item.len, "R3 slice length", run_len, cur_item.len);
          zero_run = 0;
        end
        zero_run++;
        if (zero_run <= 2 && have_last) begin
          chk(bus_c0_valid == req_c0_valid[last_port], "R4 grace c0 relay", int'(bus_c0_valid), int'(req_c0_valid[last_port]));
          chk(bus_c1_valid == req_c1_valid[last_port], "R4 grace c1 relay", int'(bus_c1_valid), int'(req_c1_valid[last_port]));
          if (req_c0_valid[last_port])
            chk(bus_c0_data == req_c0_data[last_port*W0 +: W0], "R4 grace c0 data", int'(bus_c0_data), int'(req_c0_data[last_port*W0 +: W0]));
        end else begin
          chk(!bus_c0_valid && !bus_c1_valid, "R5 quiet bus while scanning",
              int'({bus_c1_valid, bus_c0_valid}), 0);
        end
      end
    end
  end

  task automatic drain_and_idle(input string tag);
    while (sb_q.size() != 0) @(posedge clk);
    #1 req_want = '0;
    while (|req_grant) @(posedge clk);
    repeat (20) @(posedge clk);
    chk(req_grant == '0, tag, int'(req_grant), 0);
    #1;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) begin
      req_c0_data[p*W0 +: W0] = W0'(16'hA000 + p);
      req_c1_data[p*W1 +: W1] = W1'(24'hC00000 + p);
    end
    req_c0_valid = '1;
    req_c1_valid = 4'b0101;
    // Scenario 1: ports 0,1,3 want with lengths 3, 0 (->1), 5
    req_cycles[0*CW +: CW] = 8'd3;
    req_cycles[1*CW +: CW] = 8'd0;
    req_cycles[3*CW +: CW] = 8'd5;
    req_want = 4'b1011;
    push_slice(0, 1, -1);   // R1 reset slice
    push_slice(1, 1, 3);    // R3 zero treated as one
    push_slice(3, 5, 4);
    push_slice(0, 3, 3);
    push_slice(1, 1, 3);
    push_slice(3, 5, 4);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_grant == 4'b0001, "R1 port 0 granted after reset", int'(req_grant), 1);
    drain_and_idle("R10 no grant without want");

    // Scenario 2: single port 2, length 2: repeat grant after full wrap
    push_slice(2, 2, -1);
    push_slice(2, 2, 6);
    req_cycles[2*CW +: CW] = 8'd2;
    req_want = 4'b0100;
    drain_and_idle("R10 idle after scenario 2");

    // Scenario 3: maximal length on port 1
    push_slice(1, 255, -1);
    push_slice(1, 255, 6);
    req_cycles[1*CW +: CW] = 8'd255;
    req_want = 4'b0010;
    drain_and_idle("R10 idle after scenario 3");

    // Pass-through of full flags and receive channel
    bus_c0_full = 1'b1; bus_c1_full = 1'b0;
    bus_rx_valid = 1'b1; bus_rx_data = 32'hDEAD_0001;
    @(negedge clk);
    chk(req_c0_full == '1, "R8 c0 full fanout", int'(req_c0_full), 15);
    chk(req_c1_full == '0, "R8 c1 full fanout", int'(req_c1_full), 0);
    chk(req_rx_valid == '1, "R9 rx valid broadcast", int'(req_rx_valid), 15);
    for (int p = 0; p < N; p++)
      chk(req_rx_data[p*RXW +: RXW] == 32'hDEAD_0001, "R9 rx data broadcast",
          int'(req_rx_data[p*RXW +: RXW]), int'(32'hDEAD_0001));
    @(posedge clk);
    #1 bus_c0_full = 1'b0; bus_c1_full = 1'b1;
    bus_rx_valid = 1'b0; bus_rx_data = 32'h1234_5678;
    @(negedge clk);
    chk(req_c0_full == '0, "R8 c0 full cleared", int'(req_c0_full), 0);
    chk(req_c1_full == '1, "R8 c1 full fanout", int'(req_c1_full), 15);
    chk(req_rx_valid == '0, "R9 rx valid low", int'(req_rx_valid), 0);
    chk(req_rx_data[3*RXW +: RXW] == 32'h1234_5678, "R9 rx data port 3",
        int'(req_rx_data[3*RXW +: RXW]), int'(32'h1234_5678));
    chk(sb_q.size() == 0, "R7 all expected slices seen", sb_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule